// File: doc/BRIEF.md
# CPU Address Decode Window Unit

This block holds a bank of programmable address windows that steer CPU physical accesses toward a target device. Each window carries an enable bit, a 4-bit target identifier, an 8-bit attribute, a power-of-two size and an aligned 36-bit base. The lower-numbered windows can also translate the address onto a different 64-bit base before it is forwarded. The remaining windows forward it unchanged.

Software programs the bank through a word-wide register port. Writes take effect on the next clock edge and reads return data combinationally. The register layout is irregular. The remappable windows each occupy a 16-byte slot of four registers. A 16-byte reserved gap follows. The other windows each occupy an 8-byte slot of two registers. A purely combinational lookup port accepts a 36-bit address. It reports whether a window hit and, if so, which one, together with that window's target, its attribute and the translated address.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every window is disabled, every register reads zero and every lookup misses.
- R2: A window's control register keeps all 32 written bits. Bit 0 is the enable, bits 7:4 are the target, bits 15:8 are the attribute, and bits 31:16 hold the size minus one, counted in 64 KB granules.
- R3: Base register bits 31:16 give address bits 31:16, and bits 3:0 give address bits 35:32. All other base bits read as zero.
- R4: Window w, for w in 0..7, has its control register at byte offset w*0x10, its base at +4, its low remap register at +8 and its high remap register at +0xC. The low remap register keeps only bits 31:16 and reads zero elsewhere. The high remap register keeps all 32 bits.
- R5: Window w, for w in 8..19, has its control register at byte offset 0x90+(w-8)*8 and its base at +4.
- R6: Offsets 0x80 to 0x8F and offsets 0xF0 and above read zero, and writes to them change no register. Register address bits 1:0 are ignored.
- R7: Let M = {4'h0, size field, 16'hFFFF}. A window matches address A when its enable bit is set and (A & ~M) equals its 36-bit base. The covered range therefore runs from the base up to, but not including, base+size.
- R8: A window whose enable bit is 0 never matches. Writing zero to its control register disables it.
- R9: When several windows match, the lowest-numbered one is reported.
- R10: When no window matches, the hit flag is 0 and the window index, target, attribute and translated address are all zero.
- R11: A hit on windows 0..7 yields {remap high, remap low[31:16], 16'h0} | (A & M) as the 64-bit translated address.
- R12: A hit on windows 8..19 yields A, zero-extended to 64 bits, as the translated address.
- R13: On a hit, the target and attribute outputs equal bits 7:4 and bits 15:8 of the hit window's control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| lk_addr | input | 36 | Physical address to look up |
| lk_hit | output | 1 | A window matched |
| lk_win | output | 5 | Index of the matched window |
| lk_target | output | 4 | Target of the matched window |
| lk_attr | output | 8 | Attribute of the matched window |
| lk_xaddr | output | 64 | Translated address |

## Verification
The assertions take for granted that the inputs are known, two-valued values at every clock edge. The reserved-gap property relies on software writing nothing there except at offsets 0x80 to 0x8F. The randomized stimulus programs only contiguous size fields and bases aligned to their size, so the match ranges stay meaningful. Lookup addresses are drawn close to programmed bases, and bases are packed into a narrow region so that windows overlap often. Register offsets are drawn over the whole 8-bit space, so writes and reads also land in the gap and beyond the last window.

// File: rtl/awd_pkg.sv
package awd_pkg;
    typedef enum logic [2:0] {
        RK_NONE,
        RK_CTRL,
        RK_BASE,
        RK_RLO,
        RK_RHI
    } reg_kind_e;

    localparam int WIDE_STRIDE   = 16;
    localparam int NARROW_STRIDE = 8;
    localparam int HOLE_BYTES    = 16;
endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
    import awd_pkg::*;
#(
    parameter int NWIN   = 20,
    parameter int NREMAP = 8,
    parameter int REG_AW = 8,
    parameter int IDX_W  = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic [REG_AW-1:0]             reg_addr,
    input  logic [31:0]                   reg_wdata,
    output logic [31:0]                   reg_rdata,
    output logic [NWIN-1:0][31:0]         ctrl_o,
    output logic [NWIN-1:0][19:0]         base_o,
    output logic [NREMAP-1:0][15:0]       rlo_o,
    output logic [NREMAP-1:0][31:0]       rhi_o
);
    localparam int WIDE_END   = NREMAP * WIDE_STRIDE;
    localparam int NARROW_BEG = WIDE_END + HOLE_BYTES;
    localparam int NARROW_END = NARROW_BEG + (NWIN - NREMAP) * NARROW_STRIDE;
    localparam int RI_W       = (NREMAP > 1) ? $clog2(NREMAP) : 1;

    typedef struct packed {
        logic [NWIN-1:0][31:0]   ctrl;
        logic [NWIN-1:0][19:0]   base;
        logic [NREMAP-1:0][15:0] rlo;
        logic [NREMAP-1:0][31:0] rhi;
    } bank_t;

    bank_t     state_d, state_q;
    reg_kind_e kind;
    logic [IDX_W-1:0] idx;
    logic [31:0] a_ext;

    assign a_ext = 32'(reg_addr);

    // offset decode: wide slots, reserved gap, narrow slots
    always_comb begin
        kind = RK_NONE;
        idx  = '0;
        if (a_ext < 32'(WIDE_END)) begin
            idx = IDX_W'(a_ext >> 4);
            case (a_ext[3:2])
                2'd0:    kind = RK_CTRL;
                2'd1:    kind = RK_BASE;
                2'd2:    kind = RK_RLO;
                default: kind = RK_RHI;
            endcase
        end else if (a_ext >= 32'(NARROW_BEG) && a_ext < 32'(NARROW_END)) begin
            idx  = IDX_W'((a_ext - 32'(NARROW_BEG)) >> 3) + IDX_W'(NREMAP);
            kind = a_ext[2] ? RK_BASE : RK_CTRL;
        end
    end

    always_comb begin
        state_d = state_q;
        if (reg_wr) begin
            case (kind)
                RK_CTRL: state_d.ctrl[idx] = reg_wdata;
                RK_BASE: state_d.base[idx] = {reg_wdata[3:0], reg_wdata[31:16]};
                RK_RLO:  state_d.rlo[idx[RI_W-1:0]] = reg_wdata[31:16];
                RK_RHI:  state_d.rhi[idx[RI_W-1:0]] = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        case (kind)
            RK_CTRL: reg_rdata = state_q.ctrl[idx];
            RK_BASE: reg_rdata = {state_q.base[idx][15:0], 12'h000, state_q.base[idx][19:16]};
            RK_RLO:  reg_rdata = {state_q.rlo[idx[RI_W-1:0]], 16'h0000};
            RK_RHI:  reg_rdata = state_q.rhi[idx[RI_W-1:0]];
            default: reg_rdata = '0;
        endcase
    end

    assign ctrl_o = state_q.ctrl;
    assign base_o = state_q.base;
    assign rlo_o  = state_q.rlo;
    assign rhi_o  = state_q.rhi;
endmodule

// File: rtl/awd_lookup.sv
module awd_lookup #(
    parameter int NWIN   = 20,
    parameter int NREMAP = 8,
    parameter int IDX_W  = 5
) (
    input  logic [NWIN-1:0][31:0]   ctrl,
    input  logic [NWIN-1:0][19:0]   base,
    input  logic [NREMAP-1:0][15:0] rlo,
    input  logic [NREMAP-1:0][31:0] rhi,
    input  logic [35:0]             addr,
    output logic                    hit,
    output logic [IDX_W-1:0]        win,
    output logic [3:0]              target,
    output logic [7:0]              attr,
    output logic [63:0]             xaddr
);
    logic [NWIN-1:0][35:0] mask_w;
    logic [NWIN-1:0][63:0] xl;
    logic [NWIN-1:0]       match;
    logic [IDX_W-1:0]      sel;
    logic                  any;

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        assign mask_w[i] = {4'h0, ctrl[i][31:16], 16'hFFFF};
        assign match[i]  = ctrl[i][0] && ((addr & ~mask_w[i]) == {base[i], 16'h0000});
        if (i < NREMAP) begin : g_remap
            assign xl[i] = {rhi[i], rlo[i], 16'h0000} | {28'h0, addr & mask_w[i]};
        end else begin : g_pass
            assign xl[i] = {28'h0, addr};
        end
    end

    // lowest index wins: scan downward so the last assignment is the lowest
    always_comb begin
        sel = '0;
        any = 1'b0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (match[i]) begin
                sel = IDX_W'(i);
                any = 1'b1;
            end
        end
    end

    always_comb begin
        hit    = any;
        win    = '0;
        target = '0;
        attr   = '0;
        xaddr  = '0;
        if (any) begin
            win    = sel;
            target = ctrl[sel][7:4];
            attr   = ctrl[sel][15:8];
            xaddr  = xl[sel];
        end
    end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
    parameter int NWIN   = 20,
    parameter int NREMAP = 8,
    parameter int REG_AW = 8,
    localparam int IDX_W = $clog2(NWIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [35:0]       lk_addr,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_win,
    output logic [3:0]        lk_target,
    output logic [7:0]        lk_attr,
    output logic [63:0]       lk_xaddr
);
    logic [NWIN-1:0][31:0]   ctrl_w;
    logic [NWIN-1:0][19:0]   base_w;
    logic [NREMAP-1:0][15:0] rlo_w;
    logic [NREMAP-1:0][31:0] rhi_w;

    awd_regfile #(
        .NWIN(NWIN), .NREMAP(NREMAP), .REG_AW(REG_AW), .IDX_W(IDX_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ctrl_o(ctrl_w), .base_o(base_w), .rlo_o(rlo_w), .rhi_o(rhi_w)
    );

    awd_lookup #(
        .NWIN(NWIN), .NREMAP(NREMAP), .IDX_W(IDX_W)
    ) u_look (
        .ctrl(ctrl_w), .base(base_w), .rlo(rlo_w), .rhi(rhi_w),
        .addr(lk_addr), .hit(lk_hit), .win(lk_win),
        .target(lk_target), .attr(lk_attr), .xaddr(lk_xaddr)
    );
endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
    parameter int NWIN   = 20,
    parameter int NREMAP = 8,
    parameter int REG_AW = 8,
    parameter int IDX_W  = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    reg_wr,
    input logic [REG_AW-1:0]       reg_addr,
    input logic [35:0]             lk_addr,
    input logic                    lk_hit,
    input logic [IDX_W-1:0]        lk_win,
    input logic [3:0]              lk_target,
    input logic [7:0]              lk_attr,
    input logic [63:0]             lk_xaddr,
    input logic [NWIN-1:0][31:0]   ctrl_q,
    input logic [NWIN-1:0][19:0]   base_q,
    input logic [NREMAP-1:0][15:0] rlo_q,
    input logic [NREMAP-1:0][31:0] rhi_q
);
    localparam int GAP_LO = NREMAP * 16;
    localparam int GAP_HI = GAP_LO + 16;

    logic in_gap;
    assign in_gap = (32'(reg_addr) >= 32'(GAP_LO)) && (32'(reg_addr) < 32'(GAP_HI));

    p_miss_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_win == '0 && lk_target == '0 && lk_attr == '0 && lk_xaddr == '0));

    p_win_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (32'(lk_win) < 32'(NWIN)));

    p_hit_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> ctrl_q[lk_win][0]);

    p_fields_r13: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_target == ctrl_q[lk_win][7:4] && lk_attr == ctrl_q[lk_win][15:8]));

    p_passthru_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && 32'(lk_win) >= 32'(NREMAP)) |-> (lk_xaddr == {28'h0, lk_addr}));

    p_gap_inert_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && in_gap) |=> ($stable(ctrl_q) && $stable(base_q) && $stable(rlo_q) && $stable(rhi_q)));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ($stable(ctrl_q) && $stable(base_q) && $stable(rlo_q) && $stable(rhi_q)));
endmodule

bind addr_window_decoder awd_checker #(
    .NWIN(NWIN), .NREMAP(NREMAP), .REG_AW(REG_AW), .IDX_W(IDX_W)
) u_awd_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_win(lk_win),
    .lk_target(lk_target), .lk_attr(lk_attr), .lk_xaddr(lk_xaddr),
    .ctrl_q(ctrl_w), .base_q(base_w), .rlo_q(rlo_w), .rhi_q(rhi_w)
);

// File: tb/addr_window_decoder_bench.sv
module addr_window_decoder_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [35:0] lk_addr = '0;
    logic        lk_hit;
    logic [4:0]  lk_win;
    logic [3:0]  lk_target;
    logic [7:0]  lk_attr;
    logic [63:0] lk_xaddr;

    int vectors = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_window_decoder u_addr_window_decoder (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
        .lk_hit(lk_hit), .lk_win(lk_win), .lk_target(lk_target),
        .lk_attr(lk_attr), .lk_xaddr(lk_xaddr)
    );

    // reference model: register read values as software sees them
    logic [31:0] m_ctrl [20];
    logic [31:0] m_base [20];
    logic [31:0] m_rlo  [8];
    logic [31:0] m_rhi  [8];

    function automatic int slot(input int w);
        return (w < 8) ? w * 16 : 144 + (w - 8) * 8;
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int aw;
        aw = int'({a[7:2], 2'b00});
        for (int w = 0; w < 20; w++) begin
            if (aw == slot(w))     return m_ctrl[w];
            if (aw == slot(w) + 4) return m_base[w];
            if (w < 8 && aw == slot(w) + 8)  return m_rlo[w];
            if (w < 8 && aw == slot(w) + 12) return m_rhi[w];
        end
        return 32'h0;
    endfunction

    task automatic model_clear();
        for (int w = 0; w < 20; w++) begin m_ctrl[w] = 0; m_base[w] = 0; end
        for (int w = 0; w < 8; w++) begin m_rlo[w] = 0; m_rhi[w] = 0; end
    endtask

    initial model_clear();

    always @(posedge clk) begin
        if (!rst_n) model_clear();
        else if (reg_wr) begin
            int aw;
            aw = int'({reg_addr[7:2], 2'b00});
            for (int w = 0; w < 20; w++) begin
                if (aw == slot(w))     m_ctrl[w] = reg_wdata;
                if (aw == slot(w) + 4) m_base[w] = reg_wdata & 32'hFFFF_000F;
                if (w < 8 && aw == slot(w) + 8)  m_rlo[w] = reg_wdata & 32'hFFFF_0000;
                if (w < 8 && aw == slot(w) + 12) m_rhi[w] = reg_wdata;
            end
        end
    end

    task automatic model_lookup(input logic [35:0] a, output logic h, output logic [4:0] wi,
                                output logic [3:0] t, output logic [7:0] at, output logic [63:0] x);
        h = 0; wi = 0; t = 0; at = 0; x = 0;
        for (int w = 0; w < 20; w++) begin
            logic [35:0] m, b;
            m = {4'h0, m_ctrl[w][31:16], 16'hFFFF};
            b = {m_base[w][3:0], m_base[w][31:16], 16'h0000};
            if (!h && m_ctrl[w][0] && ((a & ~m) == b)) begin
                h  = 1;
                wi = 5'(w);
                t  = m_ctrl[w][7:4];
                at = m_ctrl[w][15:8];
                x  = (w < 8) ? ({m_rhi[w], m_rlo[w]} | {28'h0, a & m}) : {28'h0, a};
            end
        end
    endtask

    task automatic apply(input logic wr, input logic [7:0] ra, input logic [31:0] wd,
                         input logic [35:0] la, input string tag);
        logic eh; logic [4:0] ew; logic [3:0] et; logic [7:0] ea; logic [63:0] ex;
        logic [31:0] er;
        @(negedge clk);
        reg_wr = wr; reg_addr = ra; reg_wdata = wd; lk_addr = la;
        #1;
        er = model_read(ra);
        model_lookup(la, eh, ew, et, ea, ex);
        vectors++;
        if (reg_rdata !== er || lk_hit !== eh || lk_win !== ew || lk_target !== et ||
            lk_attr !== ea || lk_xaddr !== ex) begin
            fails++;
            $display("FAIL %s: addr=%02h rdata=%08h exp %08h | lk=%09h hit=%0b/%0b win=%0d/%0d tgt=%0h/%0h attr=%02h/%02h x=%016h/%016h",
                     tag, ra, reg_rdata, er, la, lk_hit, eh, lk_win, ew, lk_target, et,
                     lk_attr, ea, lk_xaddr, ex);
        end
    endtask

    task automatic rd(input logic [7:0] ra, input logic [35:0] la, input string tag);
        apply(1'b0, ra, 32'h0, la, tag);
    endtask

    task automatic wr(input logic [7:0] ra, input logic [31:0] wd, input string tag);
        apply(1'b1, ra, wd, 36'h0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung, expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        // R1: state during and after reset
        rd(8'h00, 36'h0, "R1");
        rd(8'h04, 36'h2_0010_0000, "R1");
        @(negedge clk); rst_n = 1'b1;
        rd(8'h98, 36'h0, "R1");
        rd(8'h0C, 36'h0_0000_0000, "R1");

        // R2: control field storage; R3: base bit packing
        wr(8'h00, 32'h000F_5A31, "R2");
        rd(8'h00, 36'h0, "R2");
        wr(8'h04, 32'h0010_FFF2, "R3");
        rd(8'h04, 36'h0, "R3");
        // R4: remap registers in wide slot
        wr(8'h08, 32'hABCD_1234, "R4");
        wr(8'h0C, 32'h0000_0001, "R4");
        rd(8'h08, 36'h0, "R4");
        rd(8'h0C, 36'h0, "R4");
        // R5: narrow slot for window 9
        wr(8'h98, 32'h0000_1C71, "R5");
        wr(8'h9C, 32'h8000_0000, "R5");
        rd(8'h98, 36'h0, "R5");
        rd(8'h9C, 36'h0, "R5");
        // R6: gap and beyond-end are inert; low address bits ignored
        wr(8'h80, 32'hFFFF_FFFF, "R6");
        wr(8'h8C, 32'hFFFF_FFFF, "R6");
        wr(8'hF0, 32'hFFFF_FFFF, "R6");
        wr(8'hFC, 32'hFFFF_FFFF, "R6");
        rd(8'h80, 36'h0, "R6");
        rd(8'hF4, 36'h0, "R6");
        rd(8'h01, 36'h0, "R6");
        rd(8'h9B, 36'h0, "R6");
        rd(8'h88, 36'h0, "R6");

        // R7 / R11 / R13: match range edges and translation
        rd(8'h00, 36'h2_0010_0123, "R11");
        rd(8'h00, 36'h2_0010_0000, "R7");
        rd(8'h00, 36'h2_001F_FFFF, "R7");
        rd(8'h00, 36'h2_0020_0000, "R7");
        rd(8'h00, 36'h2_000F_FFFF, "R10");
        rd(8'h00, 36'h3_0010_0000, "R10");
        // R12: non-remappable pass-through
        rd(8'h00, 36'h0_8000_FFFF, "R12");
        rd(8'h00, 36'h0_8001_0000, "R10");

        // R9: overlapping window 5
        wr(8'h50, 32'h00FF_2251, "R9");
        wr(8'h54, 32'h0000_0002, "R9");
        rd(8'h50, 36'h2_0010_0123, "R9");
        rd(8'h54, 36'h2_0050_0000, "R13");
        // R8: disabling window 0 exposes window 5
        wr(8'h00, 32'h0, "R8");
        rd(8'h00, 36'h2_0010_0123, "R8");
        // R8 / R12: window 19 off then on
        wr(8'hEC, 32'hC000_0000, "R5");
        wr(8'hE8, 32'h0003_3340, "R8");
        rd(8'hE8, 36'h0_C000_0000, "R8");
        wr(8'hE8, 32'h0003_3341, "R12");
        rd(8'hEC, 36'h0_C003_FFFF, "R12");
        rd(8'hEC, 36'h0_C004_0000, "R10");

        // randomized mix of legal programming, stray writes and lookups
        for (int n = 0; n < 3000; n++) begin
            int kind;
            kind = int'($urandom % 8);
            if (kind == 0) begin
                int w, k;
                logic [15:0] sz;
                w  = int'($urandom % 20);
                k  = int'($urandom % 10);
                sz = 16'((32'd1 << k) - 1);
                wr(8'(slot(w)), {sz, 8'($urandom), 4'($urandom), 3'b000, 1'(($urandom % 10) != 0)}, "R2");
            end else if (kind == 1) begin
                int w;
                logic [15:0] lo;
                w  = int'($urandom % 20);
                lo = 16'(($urandom % 8) << 12) & ~m_ctrl[w][31:16];
                wr(8'(slot(w) + 4), {lo, 12'($urandom), 4'($urandom % 2)}, "R3");
            end else if (kind == 2) begin
                int w;
                w = int'($urandom % 8);
                wr(8'(slot(w) + 8 + 4 * int'($urandom % 2)), $urandom, "R4");
            end else if (kind == 3) begin
                wr(8'($urandom), $urandom, "R6");
            end else begin
                int w;
                logic [35:0] b;
                w = int'($urandom % 20);
                b = {m_base[w][3:0], m_base[w][31:16], 16'h0000};
                rd(8'($urandom), b ^ 36'($urandom & 32'h01FF_FFFF), "R7");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule